// File: doc/BRIEF.md
# SD Card Clock Divider

This block derives the card clock of an SD/MMC host from its kernel clock. A 10-bit divider value N sets the card clock to the kernel rate over 2×N; a value of zero routes the kernel clock straight to the card. The block also tells the command and data output logic when to launch new bits: a one-cycle launch strobe in the kernel clock domain, plus a flag that says whether the launch edge is a falling edge.

Two gating conditions freeze the card clock low. The first is power saving while the bus is idle. The second is flow control while the data FIFO can neither accept nor supply data. Divided clocks always stop after a complete high phase, so no short pulse reaches the card. A new divider value or edge choice is loaded only when a high phase ends, and two width bits are decoded into a bus width code for the data path.

Top module: `sd_clk_div`

## Requirements
- R1: With a stored divider N greater than 0 and no gating, the card clock is high for exactly N kernel cycles and then low for exactly N kernel cycles, a period of 2×N.
- R2: With a stored divider of 0, the card clock follows the kernel clock. `launch_fall_o` is 1, and `launch_o` is 1 in every kernel cycle in which the clock is not gated.
- R3: With N greater than 0 and `fall_sel_i` at 0, `launch_o` pulses for one kernel cycle, in the cycle in which the card clock has just risen, and `launch_fall_o` reads 0.
- R4: With N greater than 0 and `fall_sel_i` at 1, `launch_o` pulses for one kernel cycle, in the cycle in which the card clock has just fallen, and `launch_fall_o` reads 1.
- R5: `bus_width_o` is 2 (8-bit) when `wide8_i` is 1, whatever the value of `wide4_i`. It is 1 (4-bit) when only `wide4_i` is 1, and 0 (1-bit) when both are 0.
- R6: While `pwr_save_i` and `bus_idle_i` are both 1, a divided card clock finishes its current high phase with full length and then stays low. In bypass mode the clock is held low from the next kernel falling edge onward.
- R7: While `flow_ctl_i` and `fifo_stall_i` are both 1, the card clock stops in the same way as in R6.
- R8: A change of `div_i` or `fall_sel_i` while the divided clock is running takes effect only when the current high phase ends. The high phase in progress keeps the old length.
- R9: During reset the card clock and `launch_o` are 0, and the stored divider is 0, so `launch_fall_o` reads 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Kernel clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| div_i | input | DIV_W | Divider value N; 0 selects bypass |
| fall_sel_i | input | 1 | Launch on the falling card clock edge when N is greater than 0 |
| pwr_save_i | input | 1 | Power-save enable |
| bus_idle_i | input | 1 | Bus is idle |
| flow_ctl_i | input | 1 | Flow-control enable |
| fifo_stall_i | input | 1 | FIFO can neither accept nor supply data |
| wide4_i | input | 1 | Request for a 4-bit bus |
| wide8_i | input | 1 | Request for an 8-bit bus |
| card_clk_o | output | 1 | Card clock |
| launch_o | output | 1 | One-cycle launch strobe in the kernel domain |
| launch_fall_o | output | 1 | Launch edge is a falling edge |
| bus_width_o | output | 2 | Bus width code: 0 is 1-bit, 1 is 4-bit, 2 is 8-bit |

## Verification
The divided clock and the launch strobe change at the first kernel rising edge after the cause, because each passes through one register. The bypass gate changes at the next kernel falling edge, and the bus width code is combinational. The bench drives inputs 3 ns after a rising edge and samples 2 ns after the next one, while the kernel clock is high. It compares every output against a behavioural phase model that steps on the same edges. The bypass low phase is probed separately, just after a falling edge. Directed checks count high and low samples to confirm full-length phases, late divider updates and stops that leave no short pulse.

// File: rtl/sdck_pkg.sv
package sdck_pkg;
  typedef enum logic [1:0] {
    BUS_W1 = 2'd0,
    BUS_W4 = 2'd1,
    BUS_W8 = 2'd2
  } bus_width_e;
endpackage

// File: rtl/sdck_stop_gate.sv
module sdck_stop_gate (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic pwr_save_i,
  input  logic bus_idle_i,
  input  logic flow_ctl_i,
  input  logic fifo_stall_i,
  output logic stop_o,
  output logic gate_o
);
  logic stop;
  logic gate_q;

  assign stop = (pwr_save_i & bus_idle_i) | (flow_ctl_i & fifo_stall_i);

  // enable is captured while the kernel clock is low, so the bypass clock is glitch free
  always_ff @(negedge clk_i or negedge rst_ni) begin
    if (!rst_ni) gate_q <= 1'b0;
    else         gate_q <= ~stop;
  end

  assign stop_o = stop;
  assign gate_o = gate_q;

  p_gate_follows_stop_r6: assert property (@(negedge clk_i) disable iff (!rst_ni)
    $past(stop) |-> !gate_q);
endmodule

// File: rtl/sdck_div_core.sv
module sdck_div_core #(
  parameter int DIV_W = 10
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [DIV_W-1:0] div_i,
  input  logic             fall_sel_i,
  input  logic             stop_i,
  output logic             bypass_o,
  output logic             ck_o,
  output logic             launch_o,
  output logic             fall_o
);
  logic [DIV_W-1:0] div_q, cnt_q;
  logic             ck_q, launch_q, fall_q;
  logic             bypass, terminal;

  assign bypass   = (div_q == '0);
  assign terminal = (cnt_q == div_q - 1'b1);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      div_q    <= '0;
      cnt_q    <= '0;
      ck_q     <= 1'b0;
      launch_q <= 1'b0;
      fall_q   <= 1'b0;
    end else if (bypass) begin
      div_q    <= div_i;
      fall_q   <= fall_sel_i;
      cnt_q    <= '0;
      ck_q     <= 1'b0;
      launch_q <= ~stop_i;
    end else if (ck_q) begin
      if (terminal) begin
        // end of high phase: period boundary, settings reload here
        ck_q     <= 1'b0;
        cnt_q    <= '0;
        launch_q <= fall_q;
        div_q    <= div_i;
        fall_q   <= fall_sel_i;
      end else begin
        cnt_q    <= cnt_q + 1'b1;
        launch_q <= 1'b0;
      end
    end else begin
      launch_q <= 1'b0;
      if (terminal) begin
        if (!stop_i) begin
          ck_q     <= 1'b1;
          cnt_q    <= '0;
          launch_q <= ~fall_q;
        end
      end else begin
        cnt_q <= cnt_q + 1'b1;
      end
    end
  end

  assign bypass_o = bypass;
  assign ck_o     = ck_q;
  assign launch_o = launch_q;
  assign fall_o   = fall_q;

  p_cnt_range_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !bypass |-> (cnt_q < div_q));
  p_launch_rise_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(ck_q) |-> (launch_q == !fall_q));
  p_launch_fall_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(ck_q) |-> (launch_q == $past(fall_q)));
  p_stop_low_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!bypass && !ck_q && terminal && stop_i) |=> !ck_q);
  p_div_hold_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!bypass && ck_q && !terminal) |=> $stable(div_q));
endmodule

// File: rtl/sdck_width_dec.sv
module sdck_width_dec
  import sdck_pkg::*;
(
  input  logic       wide4_i,
  input  logic       wide8_i,
  output bus_width_e width_o
);
  always_comb begin
    if (wide8_i)      width_o = BUS_W8;
    else if (wide4_i) width_o = BUS_W4;
    else              width_o = BUS_W1;
  end
endmodule

// File: rtl/sd_clk_div.sv
module sd_clk_div
  import sdck_pkg::*;
#(
  parameter int DIV_W = 10
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [DIV_W-1:0] div_i,
  input  logic             fall_sel_i,
  input  logic             pwr_save_i,
  input  logic             bus_idle_i,
  input  logic             flow_ctl_i,
  input  logic             fifo_stall_i,
  input  logic             wide4_i,
  input  logic             wide8_i,
  output logic             card_clk_o,
  output logic             launch_o,
  output logic             launch_fall_o,
  output logic [1:0]       bus_width_o
);
  logic       stop, gate, bypass, ck, fall;
  bus_width_e width;

  sdck_stop_gate u_gate (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .pwr_save_i   (pwr_save_i),
    .bus_idle_i   (bus_idle_i),
    .flow_ctl_i   (flow_ctl_i),
    .fifo_stall_i (fifo_stall_i),
    .stop_o       (stop),
    .gate_o       (gate)
  );

  sdck_div_core #(.DIV_W(DIV_W)) u_core (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .div_i      (div_i),
    .fall_sel_i (fall_sel_i),
    .stop_i     (stop),
    .bypass_o   (bypass),
    .ck_o       (ck),
    .launch_o   (launch_o),
    .fall_o     (fall)
  );

  sdck_width_dec u_width (
    .wide4_i (wide4_i),
    .wide8_i (wide8_i),
    .width_o (width)
  );

  assign card_clk_o    = bypass ? (clk_i & gate) : ck;
  assign launch_fall_o = bypass | fall;
  assign bus_width_o   = width;

  p_reset_quiet_r9: assert property (@(posedge clk_i)
    !rst_ni |-> (!launch_o && launch_fall_o));
  p_bypass_fall_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    bypass |-> launch_fall_o);
endmodule

// File: tb/sd_clk_div_test.sv
`timescale 1ns/100ps
module sd_clk_div_test;
  localparam int DIV_W = 10;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [DIV_W-1:0] div = 10'd3;
  logic fall_sel = 1'b0, pwr_save = 1'b0, bus_idle = 1'b0;
  logic flow_ctl = 1'b0, fifo_stall = 1'b0, wide4 = 1'b0, wide8 = 1'b0;
  logic card_clk, launch, launch_fall;
  logic [1:0] bus_width;

  int n_chk = 0, n_fail = 0;
  bit cmp_en = 1'b0;

  always #2.5 clk = ~clk;

  sd_clk_div #(.DIV_W(DIV_W)) uut (
    .clk_i(clk), .rst_ni(rst_n), .div_i(div), .fall_sel_i(fall_sel),
    .pwr_save_i(pwr_save), .bus_idle_i(bus_idle), .flow_ctl_i(flow_ctl),
    .fifo_stall_i(fifo_stall), .wide4_i(wide4), .wide8_i(wide8),
    .card_clk_o(card_clk), .launch_o(launch), .launch_fall_o(launch_fall),
    .bus_width_o(bus_width)
  );

  // behavioural phase model
  int m_n = 0, m_pos = 0;
  bit m_hi = 0, m_launch = 0, m_fall = 0, m_gate = 0;

  function automatic bit stopping();
    return (pwr_save && bus_idle) || (flow_ctl && fifo_stall);
  endfunction

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_n = 0; m_pos = 0; m_hi = 0; m_launch = 0; m_fall = 0;
    end else if (m_n == 0) begin
      m_n = int'(div); m_fall = fall_sel; m_pos = 0; m_hi = 0;
      m_launch = !stopping();
    end else begin
      m_launch = 0;
      m_pos++;
      if (m_hi && m_pos >= m_n) begin
        m_hi = 0; m_pos = 0; m_launch = m_fall;
        m_n = int'(div); m_fall = fall_sel;
      end else if (!m_hi && m_pos >= m_n) begin
        if (stopping()) m_pos = m_n - 1;
        else begin m_hi = 1; m_pos = 0; m_launch = !m_fall; end
      end
    end
  end

  always @(negedge clk or negedge rst_n) begin
    if (!rst_n) m_gate = 0;
    else        m_gate = !stopping();
  end

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", tag, act, exp, $time);
    end
  endtask

  function automatic int exp_width();
    return wide8 ? 2 : (wide4 ? 1 : 0);
  endfunction

  always begin
    @(posedge clk); #2;
    if (cmp_en) begin
      automatic int e_ck = (m_n == 0) ? int'(m_gate) : int'(m_hi);
      check(card_clk == e_ck, (m_n == 0) ? "R2 card clock" : "R1 card clock", card_clk, e_ck);
      check(launch == m_launch, m_fall ? "R4 launch" : "R3 launch", launch, m_launch);
      check(launch_fall == ((m_n == 0) || m_fall), "R3 R4 launch edge flag",
            launch_fall, (m_n == 0) || m_fall);
      check(int'(bus_width) == exp_width(), "R5 bus width", bus_width, exp_width());
    end
  end

  task automatic tick();
    @(posedge clk); #2;
  endtask

  task automatic wait_rise();
    bit prev = card_clk;
    for (int i = 0; i < 5000; i++) begin
      tick();
      if (!prev && card_clk) return;
      prev = card_clk;
    end
  endtask

  task automatic meas(input int n, input string tag);
    int h = 1, l = 0;
    wait_rise();
    for (int i = 0; i < 3000 && card_clk; i++) begin tick(); if (card_clk) h++; end
    for (int i = 0; i < 3000 && !card_clk; i++) begin l++; tick(); end
    check(h == n, {tag, " high length"}, h, n);
    check(l == n, {tag, " low length"}, l, n);
  endtask

  initial begin
    #(200000 * 5);
    n_fail++; n_chk++;
    $display("FAIL watchdog expired");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    #7;
    // R9: reset state
    check(card_clk == 0, "R9 card clock in reset", card_clk, 0);
    check(launch == 0, "R9 launch in reset", launch, 0);
    check(launch_fall == 1, "R9 edge flag in reset", launch_fall, 1);
    @(posedge clk); #1; rst_n = 1'b1;
    cmp_en = 1'b1;

    meas(3, "R1 N=3");
    // R5: width combinations
    tick(); #1; wide4 = 1; tick(); check(bus_width == 1, "R5 4-bit", bus_width, 1);
    #1; wide8 = 1; tick(); check(bus_width == 2, "R5 8 over 4", bus_width, 2);
    #1; wide4 = 0; tick(); check(bus_width == 2, "R5 8-bit", bus_width, 2);
    #1; wide8 = 0; tick(); check(bus_width == 0, "R5 1-bit", bus_width, 0);

    // R4: falling-edge launch, applied at the boundary
    #1; fall_sel = 1;
    meas(3, "R4 N=3");
    meas(3, "R4 N=3 again");

    // R8: change mid-high, current high keeps old length
    wait_rise();
    #1; div = 10'd5;
    begin
      int h = 1, l = 0;
      for (int i = 0; i < 100 && card_clk; i++) begin tick(); if (card_clk) h++; end
      for (int i = 0; i < 100 && !card_clk; i++) begin l++; tick(); end
      check(h == 3, "R8 old high length kept", h, 3);
      check(l == 5, "R8 new low length", l, 5);
    end
    #1; fall_sel = 0;
    meas(5, "R1 N=5");
    #1; div = 10'd1;
    meas(1, "R1 N=1");
    #1; div = 10'd4;
    meas(4, "R1 N=4");

    // R6: power save stops after a full high phase
    wait_rise();
    #1; pwr_save = 1; bus_idle = 1;
    begin
      int h = 1, lo = 0;
      for (int i = 0; i < 100 && card_clk; i++) begin tick(); if (card_clk) h++; end
      check(h == 4, "R6 high phase not cut", h, 4);
      for (int i = 0; i < 20; i++) begin tick(); if (!card_clk) lo++; end
      check(lo == 20, "R6 clock held low", lo, 20);
    end
    #1; bus_idle = 0;
    meas(4, "R6 resume");
    #1; pwr_save = 0;

    // R7: flow-control stop
    wait_rise();
    #1; flow_ctl = 1; fifo_stall = 1;
    begin
      int lo = 0;
      for (int i = 0; i < 100 && card_clk; i++) tick();
      for (int i = 0; i < 20; i++) begin tick(); if (!card_clk) lo++; end
      check(lo == 20, "R7 clock held low", lo, 20);
    end
    #1; fifo_stall = 0;
    meas(4, "R7 resume");
    #1; flow_ctl = 0;

    // R2: bypass
    #1; div = 10'd0;
    repeat (12) tick();
    check(card_clk == 1, "R2 bypass high", card_clk, 1);
    check(launch == 1, "R2 bypass launch", launch, 1);
    #1.5; check(card_clk == 0, "R2 bypass low", card_clk, 0);
    tick(); #1; pwr_save = 1; bus_idle = 1;
    repeat (2) tick();
    check(card_clk == 0, "R6 bypass gated", card_clk, 0);
    check(launch == 0, "R6 bypass no launch", launch, 0);
    #1; pwr_save = 0; bus_idle = 0; div = 10'd2;
    repeat (3) tick();
    meas(2, "R1 leave bypass N=2");
    repeat (5) tick();

    cmp_en = 1'b0;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule